// File: doc/BRIEF.md
# Radix-Selectable Number Entry Parser

This block turns a stream of ASCII characters into a binary number for a target field between 1 and 12 bits wide. It takes one character per cycle on a valid strobe and builds the number in a 12-bit accumulator. It then reports the result on a one-cycle completion pulse, together with the character that closed the entry. A level input selects the default radix, decimal or binary. A prefix character at the start of an entry can override that radix for that entry alone.

Binary digits may be written as `0`/`1` or as the tape-style letters `P` (zero) and `N` (one). Rubout characters are skipped. Only the low-order bits of the number are kept, so a user who mistypes can send as many zeros as the field has bits and then retype the number in the same string. Any character that has no meaning in the current state aborts the entry and raises a one-cycle error pulse instead of the completion pulse.

Top module: `radix_num_parser`

## Requirements
- R1: With `default_bin`=0 and no prefix, each digit `0`..`9` (0x30..0x39) updates the accumulator as acc*10+digit. The delimited entry "123," yields 123.
- R2: With `default_bin`=1 and no prefix, each `0` or `1` shifts into the accumulator's least significant bit. "1011," yields 11.
- R3: In binary radix the letter `P` (0x50) counts as bit 0 and `N` (0x4E) counts as bit 1, and the letters may be mixed with `0`/`1`.
- R4: If `D` (0x44) is the first character of an entry, that entry is decimal. If `B` (0x42) is the first character, that entry is binary. The override ends with the entry, and the next entry follows `default_bin` again.
- R5: The reported value is the accumulator masked to the low `field_width` bits. Decimal 20 in a 4-bit field gives 4. A `field_width` of 0 acts as 1 and a value above 12 acts as 12.
- R6: Carriage return (0x0D), comma (0x2C), space (0x20) and `F` (0x46) end an entry. One cycle after the strobe that carries the delimiter, `out_done` is high for one cycle, `out_value` holds the result and `out_delim` holds the delimiter code. An entry with no digits yields 0.
- R7: A rubout character (0x7F) is ignored in any position and leaves the accumulated value unchanged.
- R8: Any other character aborts the entry. This includes a digit outside the current radix and a prefix that is not the first character. One cycle after the strobe, `out_err` pulses for one cycle and `out_done` stays low. The next character begins a fresh entry in the default radix.
- R9: A synchronous active-high reset clears the accumulator, the pending entry and any radix override, and drives `out_value`, `out_delim`, `out_done` and `out_err` to zero.
- R10: Decimal accumulation wraps modulo 4096, so "5000," in a 12-bit field yields 904.
- R11: Characters presented while `in_valid` is low have no effect on the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Character strobe |
| in_char | input | 8 | ASCII character |
| default_bin | input | 1 | Default radix: 1 binary, 0 decimal |
| field_width | input | 4 | Target field width in bits |
| out_value | output | 12 | Result of the last completed entry |
| out_done | output | 1 | One-cycle completion pulse |
| out_delim | output | 8 | Delimiter that ended the last entry |
| out_err | output | 1 | One-cycle abort pulse |

## Verification
Two functions can land in the same clock edge: the completion of one entry and the first character of the next. On that edge the output stage masks and publishes the old value, while the accumulator clears and may immediately take a radix prefix or digit for the new entry. The bench provokes this by sending strings such as "7,B11,9," with strobes on consecutive cycles. It judges the result by requiring the three expected results in order, so that each override must begin and end on exactly the right edge. Error-then-delimiter strings such as "12," in binary mode cover the same edge for the abort path.

// File: rtl/num_parser_pkg.sv
package num_parser_pkg;

    localparam int ACC_W   = 12;
    localparam int WSEL_W  = $clog2(ACC_W + 1);

    localparam logic [7:0] CH_RUBOUT = 8'h7F;
    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_COMMA  = 8'h2C;
    localparam logic [7:0] CH_SPACE  = 8'h20;
    localparam logic [7:0] CH_END_F  = 8'h46;
    localparam logic [7:0] CH_PFX_D  = 8'h44;
    localparam logic [7:0] CH_PFX_B  = 8'h42;
    localparam logic [7:0] CH_ZERO_P = 8'h50;
    localparam logic [7:0] CH_ONE_N  = 8'h4E;

    typedef enum logic [2:0] {
        K_IGNORE,
        K_DIGIT,
        K_PREFIX_DEC,
        K_PREFIX_BIN,
        K_DELIM,
        K_BAD
    } char_kind_e;

    typedef struct packed {
        char_kind_e kind;
        logic [3:0] digit;
    } char_info_t;

    function automatic char_info_t classify(input logic [7:0] ch,
                                            input logic       is_bin,
                                            input logic       prefix_ok);
        char_info_t r;
        r.kind  = K_BAD;
        r.digit = '0;
        if (ch == CH_RUBOUT) begin
            r.kind = K_IGNORE;
        end else if (ch == CH_CR || ch == CH_COMMA || ch == CH_SPACE || ch == CH_END_F) begin
            r.kind = K_DELIM;
        end else if (ch == CH_PFX_D || ch == CH_PFX_B) begin
            if (prefix_ok) r.kind = (ch == CH_PFX_B) ? K_PREFIX_BIN : K_PREFIX_DEC;
        end else if (is_bin) begin
            if (ch == "0" || ch == CH_ZERO_P) begin
                r.kind = K_DIGIT;
            end else if (ch == "1" || ch == CH_ONE_N) begin
                r.kind  = K_DIGIT;
                r.digit = 4'd1;
            end
        end else if (ch >= "0" && ch <= "9") begin
            r.kind  = K_DIGIT;
            r.digit = 4'(ch - "0");
        end
        return r;
    endfunction

    function automatic logic [ACC_W-1:0] times_ten_plus(input logic [ACC_W-1:0] a,
                                                        input logic [3:0]       d);
        return (a << 3) + (a << 1) + ACC_W'(d);
    endfunction

    function automatic logic [ACC_W-1:0] field_mask(input logic [WSEL_W-1:0] w);
        logic [WSEL_W-1:0] wc;
        if (w == '0)                 wc = WSEL_W'(1);
        else if (w > WSEL_W'(ACC_W)) wc = WSEL_W'(ACC_W);
        else                         wc = w;
        return {ACC_W{1'b1}} >> (WSEL_W'(ACC_W) - wc);
    endfunction

endpackage

// File: rtl/nep_char_decode.sv
module nep_char_decode
    import num_parser_pkg::*;
(
    input  logic [7:0] ch,
    input  logic       is_bin,
    input  logic       prefix_ok,
    output char_info_t info
);
    always_comb info = classify(ch, is_bin, prefix_ok);
endmodule

// File: rtl/nep_accum.sv
module nep_accum
    import num_parser_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  char_info_t   info,
    input  logic         default_bin,
    output logic [W-1:0] acc,
    output logic         eff_bin,
    output logic         prefix_ok
);
    logic forced;
    logic forced_bin;
    logic started;
    logic entry_end;

    assign eff_bin   = forced ? forced_bin : default_bin;
    assign prefix_ok = !started;
    assign entry_end = in_valid && (info.kind == K_DELIM || info.kind == K_BAD);

    always_ff @(posedge clk) begin
        if (rst || entry_end) begin
            acc        <= '0;
            forced     <= 1'b0;
            forced_bin <= 1'b0;
            started    <= 1'b0;
        end else if (in_valid) begin
            unique case (info.kind)
                K_DIGIT: begin
                    acc     <= eff_bin ? {acc[W-2:0], info.digit[0]}
                                       : times_ten_plus(acc, info.digit);
                    started <= 1'b1;
                end
                K_PREFIX_DEC: begin
                    forced     <= 1'b1;
                    forced_bin <= 1'b0;
                    started    <= 1'b1;
                end
                K_PREFIX_BIN: begin
                    forced     <= 1'b1;
                    forced_bin <= 1'b1;
                    started    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_rubout_keeps_acc_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.kind == K_IGNORE) |=> $stable(acc));

    assert_prefix_forces_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.kind == K_PREFIX_BIN) |=> eff_bin);

    assert_abort_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && info.kind == K_BAD) |=> (acc == '0 && !forced));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (acc == '0 && prefix_ok));
endmodule

// File: rtl/nep_out_stage.sv
module nep_out_stage
    import num_parser_pkg::*;
#(
    parameter int W  = ACC_W,
    parameter int WS = WSEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_char,
    input  char_info_t    info,
    input  logic [W-1:0]  acc,
    input  logic [WS-1:0] field_width,
    output logic [W-1:0]  out_value,
    output logic          out_done,
    output logic [7:0]    out_delim,
    output logic          out_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_value <= '0;
            out_done  <= 1'b0;
            out_delim <= '0;
            out_err   <= 1'b0;
        end else begin
            out_done <= 1'b0;
            out_err  <= 1'b0;
            if (in_valid && info.kind == K_DELIM) begin
                out_done  <= 1'b1;
                out_delim <= in_char;
                out_value <= acc & field_mask(field_width);
            end else if (in_valid && info.kind == K_BAD) begin
                out_err <= 1'b1;
            end
        end
    end

    assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(out_done && out_err));

    assert_value_fits_R5: assert property (@(posedge clk) disable iff (rst)
        out_done |-> ((out_value & ~field_mask($past(field_width))) == '0));

    assert_done_from_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(in_valid));
endmodule

// File: rtl/radix_num_parser.sv
module radix_num_parser
    import num_parser_pkg::*;
#(
    parameter int W  = ACC_W,
    parameter int WS = WSEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_char,
    input  logic          default_bin,
    input  logic [WS-1:0] field_width,
    output logic [W-1:0]  out_value,
    output logic          out_done,
    output logic [7:0]    out_delim,
    output logic          out_err
);
    char_info_t   info;
    logic [W-1:0] acc;
    logic         eff_bin;
    logic         prefix_ok;

    nep_char_decode u_dec (
        .ch        (in_char),
        .is_bin    (eff_bin),
        .prefix_ok (prefix_ok),
        .info      (info)
    );

    nep_accum #(.W(W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .info        (info),
        .default_bin (default_bin),
        .acc         (acc),
        .eff_bin     (eff_bin),
        .prefix_ok   (prefix_ok)
    );

    nep_out_stage #(.W(W), .WS(WS)) u_out (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_char     (in_char),
        .info        (info),
        .acc         (acc),
        .field_width (field_width),
        .out_value   (out_value),
        .out_done    (out_done),
        .out_delim   (out_delim),
        .out_err     (out_err)
    );
endmodule

// File: tb/tb_radix_num_parser.sv
module tb_radix_num_parser;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        default_bin = 1'b0;
    logic [3:0]  field_width = 4'd12;
    logic [11:0] out_value;
    logic        out_done;
    logic [7:0]  out_delim;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_err;
        logic [11:0] v;
        logic [7:0]  d;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    radix_num_parser dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .default_bin(default_bin), .field_width(field_width),
        .out_value(out_value), .out_done(out_done),
        .out_delim(out_delim), .out_err(out_err)
    );

    task automatic exp_ok(input logic [11:0] v, input logic [7:0] d, input string tag);
        exp_t e;
        e.is_err = 1'b0; e.v = v; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic exp_err(input string tag);
        exp_t e;
        e.is_err = 1'b1; e.v = '0; e.d = '0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic send(input string s);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_char  = s[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_char  = 8'h00;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_char  = 8'h00;
    endtask

    // Monitor: pops one expectation per done or error pulse
    always @(negedge clk) begin
        if (!rst && (out_done || out_err)) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL unexpected pulse done=%0b err=%0b value=%0d expected none",
                         out_done, out_err, out_value);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_err) begin
                    if (!(out_err && !out_done)) begin
                        errors++;
                        $display("FAIL %s done=%0b err=%0b expected err=1 done=0",
                                 e.tag, out_done, out_err);
                    end
                end else if (!(out_done && !out_err && out_value == e.v && out_delim == e.d)) begin
                    errors++;
                    $display("FAIL %s done=%0b err=%0b value=%0d delim=%h expected value=%0d delim=%h",
                             e.tag, out_done, out_err, out_value, out_delim, e.v, e.d);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_value !== 12'd0 || out_done !== 1'b0 || out_err !== 1'b0 || out_delim !== 8'h00) begin
            errors++;
            $display("FAIL R9 reset state value=%0d done=%0b err=%0b delim=%h expected all zero",
                     out_value, out_done, out_err, out_delim);
        end
        rst = 1'b0;

        // R1 R6 decimal default, several delimiters
        default_bin = 1'b0; field_width = 4'd12;
        exp_ok(12'd123, 8'h2C, "R1 decimal 123"); send("123,");
        exp_ok(12'd4095, 8'h0D, "R6 cr delimiter"); send({"4095", 8'h0D});
        exp_ok(12'd0, 8'h20, "R6 empty entry"); send(" ");
        // R10 wrap modulo 4096
        exp_ok(12'd904, 8'h20, "R10 wrap 5000"); send("5000 ");
        // R5 truncation, clamps
        field_width = 4'd4;
        exp_ok(12'd4, 8'h46, "R5 twenty in 4 bits"); send("20F");
        field_width = 4'd0;
        exp_ok(12'd1, 8'h2C, "R5 width0 as 1"); send("3,");
        field_width = 4'd1;
        exp_ok(12'd0, 8'h2C, "R5 width1"); send("2,");
        field_width = 4'd15;
        exp_ok(12'd4095, 8'h2C, "R5 width15 as 12"); send("4095,");

        // R2 R3 binary default
        default_bin = 1'b1; field_width = 4'd12;
        exp_ok(12'd11, 8'h2C, "R2 binary 1011"); send("1011,");
        exp_ok(12'd25, 8'h2C, "R3 letters NNPP1"); send("NNPP1,");
        field_width = 4'd3;
        exp_ok(12'd5, 8'h2C, "R5 overtype 000101"); send("000101,");
        exp_ok(12'd5, 8'h2C, "R5 overtype 1111101"); send("1111101,");
        field_width = 4'd12;
        // R4 decimal prefix then back to binary default
        exp_ok(12'd99, 8'h2C, "R4 D prefix"); send("D99,");
        exp_ok(12'd3, 8'h2C, "R4 default restored binary"); send("11,");
        // R8 binary digit out of radix
        exp_err("R8 digit 2 in binary"); exp_ok(12'd0, 8'h2C, "R8 fresh entry after abort");
        send("12,");

        // R4 binary prefix in decimal default
        default_bin = 1'b0;
        exp_ok(12'd5, 8'h2C, "R4 B prefix"); send("B101,");
        exp_ok(12'd101, 8'h2C, "R4 default restored decimal"); send("101,");
        // R7 rubouts
        exp_ok(12'd123, 8'h2C, "R7 rubout ignored");
        send_byte(8'h7F); send("1"); send_byte(8'h7F); send("2"); send_byte(8'h7F); send("3,");
        // R8 aborts
        exp_err("R8 N in decimal"); exp_ok(12'd0, 8'h2C, "R8 after N abort"); send("1N,");
        exp_err("R8 late prefix"); exp_ok(12'd0, 8'h2C, "R8 after late prefix"); send("1B,");
        exp_err("R8 double prefix"); exp_ok(12'd1, 8'h2C, "R8 restart decimal"); send("BD1,");
        exp_err("R8 stray X"); send("X");
        // R11 strobe low
        exp_ok(12'd42, 8'h2C, "R11 invalid strobe ignored");
        send("4");
        @(negedge clk); in_valid = 1'b0; in_char = "9";
        @(negedge clk); in_char = "N";
        @(negedge clk); in_char = ",";
        send("2,");
        // back-to-back entries with prefix right after a done
        exp_ok(12'd7, 8'h2C, "R6 back to back first");
        exp_ok(12'd3, 8'h2C, "R4 back to back prefix");
        exp_ok(12'd9, 8'h2C, "R4 back to back restored");
        send("7,B11,9,");

        // R9 reset mid-entry
        send("12");
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_value !== 12'd0 || out_done !== 1'b0 || out_err !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset mid-entry value=%0d done=%0b err=%0b expected 0 0 0",
                     out_value, out_done, out_err);
        end
        rst = 1'b0;
        exp_ok(12'd3, 8'h2C, "R9 entry discarded by reset"); send("3,");

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL missing results remaining=%0d expected 0", sb.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule